// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block is the address decoder of an 8-bit home computer with 64 KB of internal RAM. Several overlay sources share parts of that address space: an interpreter ROM, an operating-system ROM, a glyph (character) ROM, a block of peripheral registers, and two ROM windows on a plug-in cartridge. It is purely combinational. For every CPU access, it takes the 16-bit address and the read/write strobe. It also takes three banking bits from the processor port and two active-low configuration pins that a cartridge may pull down. From these it produces a select for the internal target and the active-low cartridge chip selects.

The address space is split into 4 KB pages. The banking bits and the cartridge pins pick which source answers in each page. Reads and writes are decoded differently. A write into a window that currently shows ROM lands in the RAM at the same address. When the cartridge pins choose console mode, most of the space is left unmapped and the banking bits stop having any effect.

Top module: `bank_decoder`

## Requirements
- R1: With both cartridge pins high, the interpreter ROM (`selLangRom`) is selected on reads of $A000-$BFFF exactly when `loBank`=1 and `hiBank`=1. The operating-system ROM (`selSysRom`) is selected on reads of $E000-$FFFF exactly when `hiBank`=1. Every other case selects RAM in these ranges.
- R2: Outside console mode, page $D000-$DFFF selects RAM when `loBank`=0 and `hiBank`=0, whatever `charBank` is. Otherwise `charBank`=1 selects the I/O block (`selIo`) and `charBank`=0 selects the glyph ROM (`selGlyphRom`) on reads.
- R3: A write to an address whose read would select the interpreter, operating-system or glyph ROM selects RAM instead, and no ROM select is active.
- R4: `expPageASelN` is low for $DE00-$DEFF and `expPageBSelN` is low for $DF00-$DFFF, on reads and on writes alike, and only while `selIo` is high. At all other times both are high.
- R5: `cartLoSelN` and `cartHiSelN` go low only on reads. On a write they stay high, and outside console mode the write selects RAM.
- R6: With only `cartRomCfgN` low, `cartLoSelN` is low on reads of $8000-$9FFF exactly when `loBank`=1 and `hiBank`=1. The interpreter ROM stays visible as in R1.
- R7: With both cartridge pins low, `cartLoSelN` is low on reads of $8000-$9FFF when `loBank`=1 and `hiBank`=1. `cartHiSelN` is low on reads of $A000-$BFFF whenever `hiBank`=1. The interpreter ROM is never selected. Pages $D000-$FFFF follow R1 and R2.
- R8: With only `cartSysCfgN` low (console mode), the map is fixed and the banking bits are ignored. RAM is at $0000-$0FFF, `cartLoSelN` is at $8000-$9FFF, I/O is at $D000-$DFFF, and `cartHiSelN` is at $E000-$FFFF. $1000-$7FFF and $A000-$CFFF select nothing.
- R9: In console mode, a write to the unmapped ranges or to either cartridge window selects no internal target.
- R10: At most one of `selRam`, `selLangRom`, `selSysRom`, `selGlyphRom` and `selIo` is high for any access. Outside console mode, $0000-$7FFF and $C000-$CFFF always select RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | CPU address |
| rdNotWr | input | 1 | 1 = read access, 0 = write access |
| loBank | input | 1 | Banking bit for the lower ROM window |
| hiBank | input | 1 | Banking bit for the upper ROM window |
| charBank | input | 1 | Banking bit choosing I/O (1) or glyph ROM (0) |
| cartRomCfgN | input | 1 | Cartridge configuration pin A, active low |
| cartSysCfgN | input | 1 | Cartridge configuration pin B, active low |
| selRam | output | 1 | Internal RAM select, active high |
| selLangRom | output | 1 | Interpreter ROM select, active high |
| selSysRom | output | 1 | Operating-system ROM select, active high |
| selGlyphRom | output | 1 | Glyph ROM select, active high |
| selIo | output | 1 | Peripheral block select, active high |
| cartLoSelN | output | 1 | Cartridge low ROM window select, active low |
| cartHiSelN | output | 1 | Cartridge high ROM window select, active low |
| expPageASelN | output | 1 | Expansion page $DE select, active low |
| expPageBSelN | output | 1 | Expansion page $DF select, active low |

## Verification
Two functions of the block overlap in one access. The first is a write into a window that reads as ROM, which must turn into a RAM select in the same access that would otherwise raise the ROM select. The second is an expansion-page hit, which raises an external page select together with the I/O block select. The bench drives every combination of the banking bits, the cartridge pins and the strobe against one probe per 4 KB page, plus the window edges and both expansion pages. A scoreboard judges every result against a model written from the requirements.

// File: rtl/bank_pkg.sv
package bank_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    CART_NONE    = 2'd0,
    CART_LOW     = 2'd1,
    CART_DUAL    = 2'd2,
    CART_CONSOLE = 2'd3
  } cartMode_e;

  // Strobes from the mode control to the page datapath
  typedef struct packed {
    logic openBus;   // console mode: most pages unmapped
    logic langRd;    // interpreter ROM readable in upper-middle window
    logic sysRd;     // operating-system ROM readable in top window
    logic glyphRd;   // glyph ROM readable in page D
    logic ioOn;      // peripheral block occupies page D
    logic cartLoOn;  // cartridge low window at $8000
    logic cartMidOn; // cartridge high window at $A000
    logic cartTopOn; // cartridge high window at $E000
  } mapStrobes_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
(
  input  logic        loBank,
  input  logic        hiBank,
  input  logic        charBank,
  input  logic        cartRomCfgN,
  input  logic        cartSysCfgN,
  output mapStrobes_t strobes
);
  timeunit 1ns;
  timeprecision 100ps;

  cartMode_e mode;
  logic      anyRom;

  always_comb begin
    unique case ({cartRomCfgN, cartSysCfgN})
      2'b11:   mode = CART_NONE;
      2'b01:   mode = CART_LOW;
      2'b00:   mode = CART_DUAL;
      default: mode = CART_CONSOLE;
    endcase
  end

  assign anyRom = loBank | hiBank;

  always_comb begin
    strobes = '0;
    if (mode == CART_CONSOLE) begin
      strobes.openBus   = 1'b1;
      strobes.ioOn      = 1'b1;
      strobes.cartLoOn  = 1'b1;
      strobes.cartTopOn = 1'b1;
    end else begin
      strobes.sysRd   = hiBank;
      strobes.ioOn    = anyRom & charBank;
      strobes.glyphRd = anyRom & ~charBank;
      if (mode == CART_DUAL) begin
        strobes.cartMidOn = hiBank;
        strobes.cartLoOn  = loBank & hiBank;
      end else begin
        strobes.langRd   = loBank & hiBank;
        strobes.cartLoOn = (mode == CART_LOW) & loBank & hiBank;
      end
    end
  end
endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bank_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdNotWr,
  input  mapStrobes_t       strobes,
  output logic              selRam,
  output logic              selLangRom,
  output logic              selSysRom,
  output logic              selGlyphRom,
  output logic              selIo,
  output logic              cartLoSelN,
  output logic              cartHiSelN,
  output logic              expPageASelN,
  output logic              expPageBSelN
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PAGE_W    = 4;
  localparam int NUM_PAGES = 1 << PAGE_W;
  localparam int PAGE_LSB  = ADDR_W - PAGE_W;
  localparam int SUB_LSB   = PAGE_LSB - 4;

  logic [NUM_PAGES-1:0] pageHit;
  logic [3:0]           subPage;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    assign pageHit[p] = (addr[ADDR_W-1:PAGE_LSB] == PAGE_W'(p));
  end

  assign subPage = addr[PAGE_LSB-1:SUB_LSB];

  logic inLow, inGap, inLoWin, inMidWin, inPageC, inPageD, inTopWin;
  assign inLow    = pageHit[0];
  assign inGap    = |pageHit[7:1];
  assign inLoWin  = |pageHit[9:8];
  assign inMidWin = |pageHit[11:10];
  assign inPageC  = pageHit[12];
  assign inPageD  = pageHit[13];
  assign inTopWin = |pageHit[15:14];

  logic cartLo, cartHi, expA, expB;

  always_comb begin
    selRam      = 1'b0;
    selLangRom  = 1'b0;
    selSysRom   = 1'b0;
    selGlyphRom = 1'b0;
    selIo       = 1'b0;
    cartLo      = 1'b0;
    cartHi      = 1'b0;
    expA        = 1'b0;
    expB        = 1'b0;

    if (inLow) selRam = 1'b1;

    if (inGap || inPageC) selRam = !strobes.openBus;

    if (inLoWin) begin
      if (strobes.cartLoOn) begin
        if (rdNotWr) cartLo = 1'b1;
        else         selRam = !strobes.openBus;
      end else begin
        selRam = 1'b1;
      end
    end

    if (inMidWin) begin
      if (strobes.cartMidOn) begin
        if (rdNotWr) cartHi = 1'b1;
        else         selRam = 1'b1;
      end else if (strobes.langRd && rdNotWr) begin
        selLangRom = 1'b1;
      end else begin
        selRam = !strobes.openBus;
      end
    end

    if (inPageD) begin
      if (strobes.ioOn) begin
        selIo = 1'b1;
        expA  = (subPage == 4'hE);
        expB  = (subPage == 4'hF);
      end else if (strobes.glyphRd && rdNotWr) begin
        selGlyphRom = 1'b1;
      end else begin
        selRam = 1'b1;
      end
    end

    if (inTopWin) begin
      if (strobes.cartTopOn) begin
        cartHi = rdNotWr;
      end else if (strobes.sysRd && rdNotWr) begin
        selSysRom = 1'b1;
      end else begin
        selRam = 1'b1;
      end
    end
  end

  assign cartLoSelN   = !cartLo;
  assign cartHiSelN   = !cartHi;
  assign expPageASelN = !expA;
  assign expPageBSelN = !expB;
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdNotWr,
  input  logic              loBank,
  input  logic              hiBank,
  input  logic              charBank,
  input  logic              cartRomCfgN,
  input  logic              cartSysCfgN,
  output logic              selRam,
  output logic              selLangRom,
  output logic              selSysRom,
  output logic              selGlyphRom,
  output logic              selIo,
  output logic              cartLoSelN,
  output logic              cartHiSelN,
  output logic              expPageASelN,
  output logic              expPageBSelN
);
  timeunit 1ns;
  timeprecision 100ps;

  mapStrobes_t strobes;

  bank_ctrl i_ctrl (
    .loBank      (loBank),
    .hiBank      (hiBank),
    .charBank    (charBank),
    .cartRomCfgN (cartRomCfgN),
    .cartSysCfgN (cartSysCfgN),
    .strobes     (strobes)
  );

  bank_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .addr         (addr),
    .rdNotWr      (rdNotWr),
    .strobes      (strobes),
    .selRam       (selRam),
    .selLangRom   (selLangRom),
    .selSysRom    (selSysRom),
    .selGlyphRom  (selGlyphRom),
    .selIo        (selIo),
    .cartLoSelN   (cartLoSelN),
    .cartHiSelN   (cartHiSelN),
    .expPageASelN (expPageASelN),
    .expPageBSelN (expPageBSelN)
  );
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic [ADDR_W-1:0] addr,
  input logic              rdNotWr,
  input logic              hiBank,
  input logic              cartRomCfgN,
  input logic              cartSysCfgN,
  input logic              selRam,
  input logic              selLangRom,
  input logic              selSysRom,
  input logic              selGlyphRom,
  input logic              selIo,
  input logic              cartLoSelN,
  input logic              cartHiSelN,
  input logic              expPageASelN,
  input logic              expPageBSelN
);
  timeunit 1ns;
  timeprecision 100ps;

  logic consoleMode;
  assign consoleMode = cartRomCfgN && !cartSysCfgN;

  always_comb begin
    AST_ONE_TARGET: assert ($onehot0({selRam, selLangRom, selSysRom, selGlyphRom, selIo})) else $error("multiple internal targets"); // R10
    AST_WRITE_NO_ROM: assert (rdNotWr || !(selLangRom || selSysRom || selGlyphRom)) else $error("ROM selected on write"); // R3
    AST_CART_READ_ONLY: assert (rdNotWr || (cartLoSelN && cartHiSelN)) else $error("cartridge select on write"); // R5
    AST_EXP_INSIDE_IO: assert ((expPageASelN && expPageBSelN) || (selIo && addr[ADDR_W-1:ADDR_W-4] == 4'hD)) else $error("expansion select outside I/O"); // R4
    AST_DUAL_NO_LANG: assert (!((!cartRomCfgN && !cartSysCfgN) && selLangRom)) else $error("interpreter ROM in dual mode"); // R7
    AST_SYS_NEEDS_HI: assert (!selSysRom || (hiBank && !consoleMode)) else $error("OS ROM without banking bit"); // R1
    AST_CONSOLE_LOW_RAM: assert (!(consoleMode && selRam) || addr[ADDR_W-1:ADDR_W-4] == 4'h0) else $error("console RAM outside low page"); // R8
  end
endmodule

bind bank_decoder bank_decoder_chk #(.ADDR_W(ADDR_W)) i_chk (
  .addr         (addr),
  .rdNotWr      (rdNotWr),
  .hiBank       (hiBank),
  .cartRomCfgN  (cartRomCfgN),
  .cartSysCfgN  (cartSysCfgN),
  .selRam       (selRam),
  .selLangRom   (selLangRom),
  .selSysRom    (selSysRom),
  .selGlyphRom  (selGlyphRom),
  .selIo        (selIo),
  .cartLoSelN   (cartLoSelN),
  .cartHiSelN   (cartHiSelN),
  .expPageASelN (expPageASelN),
  .expPageBSelN (expPageBSelN)
);

// File: tb/test_bank_decoder.sv
module test_bank_decoder;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rdNotWr = 1'b1;
  logic        loBank = 1'b1, hiBank = 1'b1, charBank = 1'b1;
  logic        cartRomCfgN = 1'b1, cartSysCfgN = 1'b1;
  logic        selRam, selLangRom, selSysRom, selGlyphRom, selIo;
  logic        cartLoSelN, cartHiSelN, expPageASelN, expPageBSelN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bank_decoder i_bank_decoder (
    .addr(addr), .rdNotWr(rdNotWr), .loBank(loBank), .hiBank(hiBank),
    .charBank(charBank), .cartRomCfgN(cartRomCfgN), .cartSysCfgN(cartSysCfgN),
    .selRam(selRam), .selLangRom(selLangRom), .selSysRom(selSysRom),
    .selGlyphRom(selGlyphRom), .selIo(selIo), .cartLoSelN(cartLoSelN),
    .cartHiSelN(cartHiSelN), .expPageASelN(expPageASelN), .expPageBSelN(expPageBSelN)
  );

  typedef struct {
    logic [8:0]  expVal;
    logic [15:0] a;
    logic [5:0]  cfg;
    string       tag;
  } item_t;

  item_t sbQueue[$];

  // Order: {ram, lang, sys, glyph, io, cartLoN, cartHiN, expAN, expBN}
  function automatic logic [8:0] refModel(input logic [15:0] a, input logic rd,
      input logic lo, input logic hi, input logic ch, input logic ex,
      input logic gm, output string tag);
    logic ram = 0, lang = 0, sys = 0, gly = 0, io = 0;
    logic cLo = 0, cHi = 0, eA = 0, eB = 0;
    logic dual, low;
    int pg;
    pg   = int'(a[15:12]);
    dual = !ex && !gm;
    low  = !ex && gm;
    tag  = "R10";
    if (ex && !gm) begin
      tag = rd ? "R8" : "R9";
      if (pg == 0) ram = 1;
      else if (pg == 8 || pg == 9) cLo = rd;
      else if (pg == 13) begin io = 1; eA = (a[11:8] == 4'hE); eB = (a[11:8] == 4'hF); end
      else if (pg >= 14) cHi = rd;
    end else if (pg <= 7 || pg == 12) begin
      ram = 1;
    end else if (pg <= 9) begin
      if ((low || dual) && lo && hi) begin
        tag = rd ? (dual ? "R7" : "R6") : "R5";
        cLo = rd; ram = !rd;
      end else begin
        ram = 1; tag = low ? "R6" : "R10";
      end
    end else if (pg <= 11) begin
      if (dual && hi) begin
        tag = rd ? "R7" : "R5"; cHi = rd; ram = !rd;
      end else if (!dual && lo && hi) begin
        tag = rd ? "R1" : "R3"; lang = rd; ram = !rd;
      end else begin
        ram = 1; tag = dual ? "R7" : "R1";
      end
    end else if (pg == 13) begin
      if (!lo && !hi) begin
        ram = 1; tag = "R2";
      end else if (ch) begin
        io = 1; eA = (a[11:8] == 4'hE); eB = (a[11:8] == 4'hF);
        tag = (eA || eB) ? "R4" : "R2";
      end else begin
        gly = rd; ram = !rd; tag = rd ? "R2" : "R3";
      end
    end else begin
      if (hi) begin sys = rd; ram = !rd; tag = rd ? "R1" : "R3"; end
      else begin ram = 1; tag = "R1"; end
    end
    return {ram, lang, sys, gly, io, !cLo, !cHi, !eA, !eB};
  endfunction

  task automatic driveAccess(input logic [15:0] a, input logic [5:0] cfg);
    item_t it;
    string tg;
    @(posedge clk);
    #1;
    {rdNotWr, loBank, hiBank, charBank, cartRomCfgN, cartSysCfgN} = cfg;
    addr = a;
    it.expVal = refModel(a, cfg[5], cfg[4], cfg[3], cfg[2], cfg[1], cfg[0], tg);
    it.a   = a;
    it.cfg = cfg;
    it.tag = tg;
    sbQueue.push_back(it);
  endtask

  // Monitor: compares away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQueue.size() > 0) begin
        item_t it;
        logic [8:0] got;
        it  = sbQueue.pop_front();
        got = {selRam, selLangRom, selSysRom, selGlyphRom, selIo,
               cartLoSelN, cartHiSelN, expPageASelN, expPageBSelN};
        checks++;
        if (got !== it.expVal) begin
          fails++;
          $display("FAIL %s addr=%h cfg=%b actual=%b expected=%b",
                   it.tag, it.a, it.cfg, got, it.expVal);
        end
      end
    end
  end

  logic [15:0] probes [22];

  initial begin
    for (int p = 0; p < 16; p++) probes[p] = {p[3:0], 12'h5A7};
    probes[16] = 16'hDE00;
    probes[17] = 16'hDFFF;
    probes[18] = 16'h0FFF;
    probes[19] = 16'h1000;
    probes[20] = 16'h9FFF;
    probes[21] = 16'hA000;

    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset-time defaults: read of page 0 with no cartridge -> RAM (R10)
    driveAccess(16'h0000, 6'b1_111_11);

    for (int c = 0; c < 64; c++) begin
      for (int i = 0; i < 22; i++) begin
        driveAccess(probes[i], c[5:0]);
      end
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule